// File: doc/BRIEF.md
# Send Packet Echo Retry Buffer

This block sits on the source side of a split send/echo link protocol. The local agent hands it outgoing send packets. The block gives each accepted packet a 6-bit sequence number and keeps a copy in an entry of its own. It then offers the packet to the ring inserter. The copy stays in place after transmission until the destination answers with an echo that carries the same sequence number and class. A "done" echo frees the entry. A "retry" echo puts the stored packet back in line, and it is sent again unchanged.

Request and response packets draw on separate entry pools. A burst of requests can therefore never take the space that responses need, and each class always keeps at least one entry of its own. Echo indications arrive already decoded and have no ready signal, so they are always taken. Space for an echo is the entry that was claimed when the packet was first accepted. An echo that matches no waiting entry changes nothing and raises an error flag.

Top module: `echo_retry_buf`

## Requirements
- R1: While reset is held and right after it, `out_valid` and `echo_err` are 0 and `in_ready` is 1.
- R2: An accepted packet is emitted on the output with the same data and class it was accepted with, and with the sequence number given to it at acceptance.
- R3: Sequence numbers are given out starting at 0 after reset and rise by one for each accepted packet, wrapping from 63 to 0.
- R4: After a packet is emitted, its entry stays occupied and the packet is not emitted again unless a retry echo for it arrives.
- R5: A done echo (`echo_retry`=0) whose sequence and class match a waiting entry frees that entry. The packet is never emitted again, and the class regains that unit of capacity on `in_ready`.
- R6: A retry echo (`echo_retry`=1) whose sequence and class match a waiting entry makes the same packet, with the same sequence number, appear on the output again. The entry stays occupied afterwards.
- R7: Within one class, a packet waiting for retransmission is emitted before any packet that has never been sent.
- R8: The request class (`in_class`=0) holds at most `N_REQ` packets and the response class (`in_class`=1) at most `N_RSP`. When one class is full, `in_ready` is 0 for that class only, and the other class is still accepted.
- R9: When both classes have a packet ready, the output alternates classes. If neither class has been served since reset, the request class goes first.
- R10: An echo with no waiting entry of the same sequence number and class is ignored, and `echo_err` is 1 for exactly the following cycle. An echo that matches leaves `echo_err` at 0.
- R11: A sequence number is not reused while an entry holds it. If the next number to be given out is still held, `in_ready` is 0 for both classes until that entry is freed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | New packet offered by the local agent |
| in_class | input | 1 | Class of the new packet: 0 request, 1 response |
| in_data | input | PKT_W | New packet contents |
| in_ready | output | 1 | New packet will be accepted this cycle |
| echo_valid | input | 1 | Decoded echo present |
| echo_seq | input | SEQ_W | Sequence number carried by the echo |
| echo_class | input | 1 | Class named by the echo |
| echo_retry | input | 1 | 1 retry, 0 done |
| echo_err | output | 1 | Previous-cycle echo matched no waiting entry |
| out_valid | output | 1 | Packet offered to the ring inserter |
| out_ready | input | 1 | Ring inserter takes the packet |
| out_class | output | 1 | Class of the offered packet |
| out_seq | output | SEQ_W | Sequence number of the offered packet |
| out_data | output | PKT_W | Offered packet contents |

## Verification
Most faults in the entry states appear on the output stream. A lost entry shows up as a retry that never comes back, or as a done echo that raises `echo_err` one cycle later. An entry that is wrongly re-armed shows up as an extra packet, which the scoreboard reports the moment it leaves. A mistake in the pool boundaries or the sequence counter shows at `in_ready` in the same cycle the class fills or the counter reaches a held number. Reaching that state takes one full lap of the 64 sequence numbers, so the bench runs that lap with one entry held the whole time.

// File: rtl/echo_retry_buf.sv
module echo_retry_buf #(
  parameter int PKT_W = 32,
  parameter int SEQ_W = 6,
  parameter int N_REQ = 4,
  parameter int N_RSP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_class,
  input  logic [PKT_W-1:0] in_data,
  output logic             in_ready,
  input  logic             echo_valid,
  input  logic [SEQ_W-1:0] echo_seq,
  input  logic             echo_class,
  input  logic             echo_retry,
  output logic             echo_err,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_class,
  output logic [SEQ_W-1:0] out_seq,
  output logic [PKT_W-1:0] out_data
);
  localparam int N  = N_REQ + N_RSP;
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [1:0] S_FREE = 2'd0, S_NEW = 2'd1, S_WAIT = 2'd2, S_RTRY = 2'd3;

  logic [1:0]       st_q [N];
  logic [SEQ_W-1:0] sq_q [N];
  logic [PKT_W-1:0] dt_q [N];
  logic [SEQ_W-1:0] ctr_q;
  logic             last_q;
  logic             err_q;

  logic [1:0]    free_v, rt_v, nw_v, pend;
  logic [IW-1:0] free_i [2];
  logic [IW-1:0] rt_i [2];
  logic [IW-1:0] nw_i [2];
  logic          seq_busy, hit, cj;
  logic [IW-1:0] hit_i, sel_i;
  logic          sel_c, accept, send;

  always_comb begin
    free_v = '0; rt_v = '0; nw_v = '0;
    for (int c = 0; c < 2; c++) begin
      free_i[c] = '0; rt_i[c] = '0; nw_i[c] = '0;
    end
    seq_busy = 1'b0; hit = 1'b0; hit_i = '0; cj = 1'b0;
    for (int j = N - 1; j >= 0; j--) begin
      cj = (j >= N_REQ);
      if (st_q[j] == S_FREE) begin
        free_v[cj] = 1'b1; free_i[cj] = IW'(j);
      end else if (sq_q[j] == ctr_q) begin
        seq_busy = 1'b1;
      end
      if (st_q[j] == S_RTRY) begin
        rt_v[cj] = 1'b1; rt_i[cj] = IW'(j);
      end
      if (st_q[j] == S_NEW) begin
        nw_v[cj] = 1'b1; nw_i[cj] = IW'(j);
      end
      if (echo_valid && st_q[j] == S_WAIT && sq_q[j] == echo_seq && echo_class == cj) begin
        hit = 1'b1; hit_i = IW'(j);
      end
    end
  end

  assign pend      = rt_v | nw_v;
  assign sel_c     = (&pend) ? ~last_q : pend[1];
  assign sel_i     = rt_v[sel_c] ? rt_i[sel_c] : nw_i[sel_c];
  assign out_valid = |pend;
  assign out_class = sel_c;
  assign out_seq   = sq_q[sel_i];
  assign out_data  = dt_q[sel_i];
  assign in_ready  = free_v[in_class] && !seq_busy;
  assign echo_err  = err_q;
  assign accept    = in_valid && in_ready;
  assign send      = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < N; j++) st_q[j] <= S_FREE;
      ctr_q  <= '0;
      last_q <= 1'b1;
      err_q  <= 1'b0;
    end else begin
      for (int j = 0; j < N; j++) begin
        if (accept && IW'(j) == free_i[in_class] && (j >= N_REQ) == in_class) st_q[j] <= S_NEW;
        if (send && IW'(j) == sel_i) st_q[j] <= S_WAIT;
        if (hit && IW'(j) == hit_i) st_q[j] <= echo_retry ? S_RTRY : S_FREE;
      end
      if (accept) ctr_q <= ctr_q + 1'b1;
      if (send) last_q <= sel_c;
      err_q <= echo_valid && !hit;
    end
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < N; j++) begin
      if (accept && IW'(j) == free_i[in_class] && (j >= N_REQ) == in_class) begin
        sq_q[j] <= ctr_q;
        dt_q[j] <= in_data;
      end
    end
  end
endmodule

module echo_retry_buf_chk #(
  parameter int N_REQ = 4,
  parameter int N_RSP = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_class,
  input logic       echo_valid,
  input logic       echo_retry,
  input logic       echo_class,
  input logic       echo_err,
  input logic       out_valid,
  input logic       out_ready,
  input logic       out_class,
  input logic       hit,
  input logic [1:0] pend
);
  localparam int CW = $clog2(N_REQ + N_RSP + 1) + 1;
  logic [CW-1:0] cnt_req, cnt_rsp;
  logic          lastc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_req <= '0;
      cnt_rsp <= '0;
      lastc   <= 1'b1;
    end else begin
      cnt_req <= cnt_req + CW'(in_valid && in_ready && !in_class)
                         - CW'(echo_valid && hit && !echo_retry && !echo_class);
      cnt_rsp <= cnt_rsp + CW'(in_valid && in_ready && in_class)
                         - CW'(echo_valid && hit && !echo_retry && echo_class);
      if (out_valid && out_ready) lastc <= out_class;
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_req <= CW'(N_REQ) && cnt_rsp <= CW'(N_RSP));
  // R8
  ready_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (in_class ? (cnt_rsp < CW'(N_RSP)) : (cnt_req < CW'(N_REQ))));
  // R10
  err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (echo_valid && !hit) |=> echo_err);
  // R10
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(echo_valid && !hit) |=> !echo_err);
  // R9
  class_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && pend == 2'b11) |-> out_class != lastc);
endmodule

bind echo_retry_buf echo_retry_buf_chk #(.N_REQ(N_REQ), .N_RSP(N_RSP)) u_chk (.*);

// File: tb/echo_retry_buf_test.sv
`timescale 1ns/1ps
module echo_retry_buf_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        in_valid = 1'b0, in_class = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic        echo_valid = 1'b0, echo_class = 1'b0, echo_retry = 1'b0;
  logic [5:0]  echo_seq = '0;
  logic        echo_err, out_valid, out_class;
  logic        out_ready = 1'b1;
  logic [5:0]  out_seq;
  logic [31:0] out_data;

  always #2 clk = ~clk;

  echo_retry_buf uut (.*);

  typedef struct packed { logic c; logic [5:0] s; logic [31:0] d; } item_t;
  item_t exp_q[$];
  logic [5:0] nseq = '0;
  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk); #1;
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0)
        chk(0, "R4", "unexpected packet", {out_class, out_seq, out_data}, 0);
      else begin
        item_t it;
        it = exp_q.pop_front();
        chk(out_class == it.c && out_seq == it.s && out_data == it.d, "R2/R3",
            "emitted packet", {out_class, out_seq, out_data}, it);
      end
    end
  end

  task automatic send(input logic c, input logic [31:0] d, input bit push, output logic [5:0] s);
    @(negedge clk);
    in_valid = 1'b1; in_class = c; in_data = d;
    #1 chk(in_ready, "R8", "in_ready on send", in_ready, 1);
    s = nseq;
    if (push) exp_q.push_back({c, nseq, d});
    nseq++;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic echo(input logic [5:0] s, input logic c, input logic r, input logic ee, input string req);
    @(negedge clk);
    echo_valid = 1'b1; echo_seq = s; echo_class = c; echo_retry = r;
    @(negedge clk);
    echo_valid = 1'b0;
    #1 chk(echo_err == ee, req, "echo_err", echo_err, ee);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    summary();
  end

  initial begin
    logic [5:0] s0, s1, s2, sr, sc, sd, se, sf, sg, sh, sx, sy;
    logic [5:0] hs [4];
    idle(3);
    #1;
    // R1
    chk(!out_valid, "R1", "out_valid in reset", out_valid, 0);
    chk(in_ready, "R1", "in_ready in reset", in_ready, 1);
    chk(!echo_err, "R1", "echo_err in reset", echo_err, 0);
    @(negedge clk) rst_n = 1'b1;
    #1 chk(!out_valid && in_ready, "R1", "after reset", {out_valid, in_ready}, 1);

    // R2 R3 R4: single request, held after emission
    send(0, 32'hA0A0_0001, 1, s0);
    idle(5); #1;
    chk(!out_valid, "R4", "no resend without echo", out_valid, 0);
    chk(exp_q.size() == 0, "R2", "packet emitted", exp_q.size(), 0);
    // R5
    echo(s0, 0, 0, 0, "R5");
    idle(3); #1 chk(!out_valid, "R5", "freed entry silent", out_valid, 0);

    // R6: retry resends unchanged
    send(1, 32'hB1B1_0002, 1, s1);
    idle(3);
    exp_q.push_back({1'b1, s1, 32'hB1B1_0002});
    echo(s1, 1, 1, 0, "R6");
    idle(3); #1 chk(exp_q.size() == 0, "R6", "retry emitted", exp_q.size(), 0);
    echo(s1, 1, 0, 0, "R6");

    // R10: unmatched echoes ignored
    send(0, 32'hC2C2_0003, 1, s2);
    idle(3);
    echo(6'd40, 0, 0, 1, "R10");
    echo(s2, 1, 0, 1, "R10");
    idle(2); #1 chk(!out_valid, "R10", "no output after bad echo", out_valid, 0);
    echo(s2, 0, 0, 0, "R10");

    // R8: request pool full, response still accepted
    for (int i = 0; i < 4; i++) send(0, 32'h8000_0000 + i, 1, hs[i]);
    idle(3);
    @(negedge clk) in_class = 0;
    #1 chk(!in_ready, "R8", "full request pool", in_ready, 0);
    in_class = 1;
    #1 chk(in_ready, "R8", "response still open", in_ready, 1);
    send(1, 32'hD0D0_0004, 1, sr);
    idle(3);
    echo(hs[0], 0, 0, 0, "R5");
    in_class = 0;
    #1 chk(in_ready, "R5", "request capacity back", in_ready, 1);
    for (int i = 1; i < 4; i++) echo(hs[i], 0, 0, 0, "R5");
    echo(sr, 1, 0, 0, "R5");

    // R7: retry before new in the same class
    send(0, 32'h7000_0070, 1, sc);
    idle(3);
    @(negedge clk) out_ready = 1'b0;
    send(0, 32'h7000_0071, 0, sd);
    exp_q.push_back({1'b0, sc, 32'h7000_0070});
    echo(sc, 0, 1, 0, "R6");
    exp_q.push_back({1'b0, sd, 32'h7000_0071});
    @(negedge clk) out_ready = 1'b1;
    idle(4); #1 chk(exp_q.size() == 0, "R7", "retry then new", exp_q.size(), 0);
    echo(sc, 0, 0, 0, "R7");
    echo(sd, 0, 0, 0, "R7");

    // R9: class alternation, last served was a request
    @(negedge clk) out_ready = 1'b0;
    send(0, 32'hE000_0001, 0, se);
    send(0, 32'hF000_0002, 0, sf);
    send(1, 32'h6000_0003, 0, sg);
    send(1, 32'h4000_0004, 0, sh);
    exp_q.push_back({1'b1, sg, 32'h6000_0003});
    exp_q.push_back({1'b0, se, 32'hE000_0001});
    exp_q.push_back({1'b1, sh, 32'h4000_0004});
    exp_q.push_back({1'b0, sf, 32'hF000_0002});
    @(negedge clk) out_ready = 1'b1;
    idle(6); #1 chk(exp_q.size() == 0, "R9", "alternating drain", exp_q.size(), 0);
    echo(se, 0, 0, 0, "R9");
    echo(sf, 0, 0, 0, "R9");
    echo(sg, 1, 0, 0, "R9");
    echo(sh, 1, 0, 0, "R9");

    // R11 R3: full lap of sequence numbers with one entry held
    send(0, 32'h9999_0009, 1, sx);
    idle(3);
    for (int i = 0; i < 63; i++) begin
      send(1, 32'h5500_0000 + i, 1, sy);
      echo(sy, 1, 0, 0, "R3");
    end
    @(negedge clk) in_class = 1;
    #1 chk(!in_ready, "R11", "held number blocks", in_ready, 0);
    chk(nseq == sx, "R3", "counter wrapped", nseq, sx);
    echo(sx, 0, 0, 0, "R11");
    chk(in_ready, "R11", "freed number reusable", in_ready, 1);
    send(1, 32'h1234_5678, 1, sy);
    idle(3);
    chk(sy == sx, "R3", "reused sequence", sy, sx);
    echo(sy, 1, 0, 0, "R11");
    idle(3);
    chk(exp_q.size() == 0, "R2", "scoreboard drained", exp_q.size(), 0);
    summary();
  end
endmodule